// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block lets two processors that share a chip exchange short messages and signal each other. Each of the two ports owns four 16-bit mailboxes. A port posts a message by writing one of its own mailboxes, and the other port picks it up by reading that mailbox through its own read window. Writing the upper byte of a mailbox flags an interrupt toward the other port. Reading the upper byte from the other side acknowledges that interrupt and leaves the stored message unchanged.

Each port accesses the block with an active-low select strobe, a 6-bit address, a write flag, two byte enables and 16-bit data buses. An access takes effect once, on the clock edge where a high-to-low change of the strobe is first seen. A small strobe state machine per port has two states. ST_HOLD is the reset state and means the strobe has been low, or has not yet been seen high. ST_IDLE means the strobe is high and armed. The transition "arm" goes from ST_HOLD to ST_IDLE when the strobe is high. The transition "fire" goes from ST_IDLE to ST_HOLD when the strobe is low, and it produces the single access event. Reads return data while the strobe is low. Each port has one control word that packs its mask, its post-mask cause bits and its pre-mask status bits. It also has an active-low interrupt output.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: An access acts exactly once, on the first rising clock edge at which the select is seen low after being seen high. Keeping the select low performs no further action, even if the write data changes.
- R2: A write to address 0x20+k (k = 0..3) stores into the port's own mailbox k. Byte enable bit 1 writes data bits 15:8 and bit 0 writes bits 7:0. A byte that is not enabled keeps its value.
- R3: A write to 0x20+k that has byte enable bit 1 set makes mailbox k pending toward the opposite port. A write of the lower byte alone does not.
- R4: A read of address 0x24+k returns the opposite port's mailbox k.
- R5: A read of 0x24+k with byte enable bit 1 set clears this port's pending status and cause for mailbox k, and leaves the data unchanged. A read with bit 0 alone does not clear them.
- R6: A read of the port's own mailboxes at 0x20+k returns their contents and has no effect on any interrupt state.
- R7: Address 0x28 reads as follows. Bits 3:0 hold the mask. Bits 7:4 hold the cause bits. Bits 11:8 hold the status bits. Bits 15:12 read as 0. Each field has one bit per mailbox, with bit 0 for mailbox 0. A cause or status bit reads 0 while that mailbox is pending and 1 otherwise.
- R8: A write to 0x28 with byte enable bit 0 set loads all four mask bits from write data bits 3:0. A mask bit of 1 disables the interrupt and 0 enables it. Only the writing port's own mask changes. A write to 0x28 without byte enable bit 0 leaves the mask unchanged.
- R9: The status bit becomes pending on every set. The cause bit becomes pending only when the mailbox is unmasked at the moment of the set.
- R10: The interrupt output is low exactly when some cause bit is pending and its mask bit is 0.
- R11: Writes to any address other than 0x20..0x23 and 0x28 change nothing. Reads of addresses outside 0x20..0x28 return 0.
- R12: Synchronous reset sets every mask bit to 1 and clears every status and cause bit. All mailboxes read 0 and both interrupt outputs are high.
- R13: When a set and a clear of the same mailbox interrupt occur on the same clock edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_sel_n | input | 1 | Port A mailbox select strobe, active low |
| a_addr | input | 6 | Port A register address |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_be | input | 2 | Port A byte enables, bit 1 upper byte |
| a_wdata | input | 16 | Port A write data |
| a_rdata | output | 16 | Port A read data |
| a_irq_n | output | 1 | Port A interrupt, active low |
| b_sel_n | input | 1 | Port B mailbox select strobe, active low |
| b_addr | input | 6 | Port B register address |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_be | input | 2 | Port B byte enables, bit 1 upper byte |
| b_wdata | input | 16 | Port B write data |
| b_rdata | output | 16 | Port B read data |
| b_irq_n | output | 1 | Port B interrupt, active low |

## Verification
The hardest case to produce from the ports is a set and a clear of the same mailbox landing on the same clock edge. The bench reaches it by lowering both strobes on the same falling clock edge. One port writes the upper byte of mailbox 0 while the other port acknowledges that mailbox, and the bench then checks that the control word still shows the bit as pending. The split between masked cause and unmasked status also needs an ordered sequence. The bench masks a source, sets it, unmasks it, and checks that the cause bit stays clear and the interrupt stays high.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } strobe_t;

    localparam int unsigned MBX_WR_BASE = 32;
endpackage

// File: rtl/mbox_port_fsm.sv
module mbox_port_fsm
    import mbox_pkg::*;
#(
    parameter int unsigned AW      = 6,
    parameter int unsigned N       = 4,
    parameter int unsigned WR_BASE = MBX_WR_BASE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [1:0]    be,
    output logic          ev,
    output logic [N-1:0]  wr_hit,
    output logic [N-1:0]  rd_clr,
    output logic          mask_we
);
    localparam int unsigned RD_BASE = WR_BASE + N;
    localparam int unsigned CT_ADDR = WR_BASE + 2 * N;

    strobe_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_HOLD;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        ev   = 1'b0;
        unique case (st_q)
            ST_IDLE: if (!sel_n) begin
                st_d = ST_HOLD;
                ev   = 1'b1;
            end
            ST_HOLD: if (sel_n) st_d = ST_IDLE;
            default: st_d = ST_HOLD;
        endcase
    end

    always_comb begin
        for (int k = 0; k < N; k++) begin
            wr_hit[k] = ev && we && (addr == AW'(WR_BASE + k));
            rd_clr[k] = ev && !we && be[1] && (addr == AW'(RD_BASE + k));
        end
        mask_we = ev && we && be[0] && (addr == AW'(CT_ADDR));
    end
endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
    parameter int unsigned N  = 4,
    parameter int unsigned DW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         wr_hit,
    input  logic [1:0]           be,
    input  logic [DW-1:0]        wdata,
    output logic [N-1:0][DW-1:0] data,
    output logic [N-1:0]         set_req
);
    localparam int unsigned HB = DW / 2;

    for (genvar k = 0; k < N; k++) begin : g_mbx
        always_ff @(posedge clk) begin
            if (rst) begin
                data[k] <= '0;
            end else if (wr_hit[k]) begin
                if (be[0]) data[k][HB-1:0]  <= wdata[HB-1:0];
                if (be[1]) data[k][DW-1:HB] <= wdata[DW-1:HB];
            end
        end
        assign set_req[k] = wr_hit[k] & be[1];
    end
endmodule

// File: rtl/mbox_irq_regs.sv
module mbox_irq_regs #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_req,
    input  logic [N-1:0] clr_req,
    input  logic         mask_we,
    input  logic [N-1:0] mask_wdata,
    output logic [N-1:0] status,
    output logic [N-1:0] cause,
    output logic [N-1:0] mask,
    output logic         irq_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            cause  <= '0;
            mask   <= '1;
        end else begin
            status <= (status & ~clr_req) | set_req;
            cause  <= (cause & ~clr_req) | (set_req & ~mask);
            if (mask_we) mask <= mask_wdata;
        end
    end

    assign irq_n = ~|(cause & ~mask);
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
    import mbox_pkg::*;
#(
    parameter int unsigned AW    = 6,
    parameter int unsigned DW    = 16,
    parameter int unsigned N_MBX = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_sel_n,
    input  logic [AW-1:0] a_addr,
    input  logic          a_we,
    input  logic [1:0]    a_be,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_irq_n,
    input  logic          b_sel_n,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we,
    input  logic [1:0]    b_be,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_irq_n
);
    localparam int unsigned NP      = 2;
    localparam int unsigned RD_BASE = MBX_WR_BASE + N_MBX;
    localparam int unsigned CT_ADDR = MBX_WR_BASE + 2 * N_MBX;

    logic [NP-1:0]                   sel_n_v, we_v, ev_v, mask_we_v, irq_n_v;
    logic [NP-1:0][AW-1:0]           addr_v;
    logic [NP-1:0][1:0]              be_v;
    logic [NP-1:0][DW-1:0]           wdata_v, rdata_v;
    logic [NP-1:0][N_MBX-1:0]        wr_hit_v, clr_v, set_v;
    logic [NP-1:0][N_MBX-1:0]        status_v, cause_v, mask_v;
    logic [NP-1:0][N_MBX-1:0][DW-1:0] mbx_v;

    assign sel_n_v = {b_sel_n, a_sel_n};
    assign we_v    = {b_we, a_we};
    assign addr_v  = {b_addr, a_addr};
    assign be_v    = {b_be, a_be};
    assign wdata_v = {b_wdata, a_wdata};
    assign a_rdata = rdata_v[0];
    assign b_rdata = rdata_v[1];
    assign a_irq_n = irq_n_v[0];
    assign b_irq_n = irq_n_v[1];

    for (genvar p = 0; p < NP; p++) begin : g_port
        localparam int unsigned Q = NP - 1 - p;

        mbox_port_fsm #(.AW(AW), .N(N_MBX), .WR_BASE(MBX_WR_BASE)) i_fsm (
            .clk     (clk),
            .rst     (rst),
            .sel_n   (sel_n_v[p]),
            .addr    (addr_v[p]),
            .we      (we_v[p]),
            .be      (be_v[p]),
            .ev      (ev_v[p]),
            .wr_hit  (wr_hit_v[p]),
            .rd_clr  (clr_v[p]),
            .mask_we (mask_we_v[p])
        );

        mbox_store #(.N(N_MBX), .DW(DW)) i_store (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (wr_hit_v[p]),
            .be      (be_v[p]),
            .wdata   (wdata_v[p]),
            .data    (mbx_v[p]),
            .set_req (set_v[p])
        );

        mbox_irq_regs #(.N(N_MBX)) i_irq (
            .clk        (clk),
            .rst        (rst),
            .set_req    (set_v[Q]),
            .clr_req    (clr_v[p]),
            .mask_we    (mask_we_v[p]),
            .mask_wdata (wdata_v[p][N_MBX-1:0]),
            .status     (status_v[p]),
            .cause      (cause_v[p]),
            .mask       (mask_v[p]),
            .irq_n      (irq_n_v[p])
        );

        always_comb begin
            rdata_v[p] = '0;
            if (!sel_n_v[p]) begin
                for (int k = 0; k < N_MBX; k++) begin
                    if (addr_v[p] == AW'(MBX_WR_BASE + k)) rdata_v[p] = mbx_v[p][k];
                    if (addr_v[p] == AW'(RD_BASE + k))     rdata_v[p] = mbx_v[Q][k];
                end
                if (addr_v[p] == AW'(CT_ADDR))
                    rdata_v[p] = DW'({~status_v[p], ~cause_v[p], mask_v[p]});
            end
        end
    end
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk #(
    parameter int unsigned N  = 4,
    parameter int unsigned DW = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic [1:0]                ev,
    input logic [1:0][N-1:0]         wr_hit,
    input logic [1:0][N-1:0]         set_req,
    input logic [1:0][N-1:0]         clr_req,
    input logic [1:0][N-1:0]         status,
    input logic [1:0][N-1:0]         cause,
    input logic [1:0][N-1:0]         mask,
    input logic [1:0]                irq_n,
    input logic [1:0][N-1:0][DW-1:0] mbx
);
    for (genvar p = 0; p < 2; p++) begin : g_chk
        localparam int unsigned Q = 1 - p;

        assert_one_shot_R1: assert property (@(posedge clk) disable iff (rst)
            ev[p] |=> !ev[p]);

        assert_own_hold_R6: assert property (@(posedge clk) disable iff (rst)
            (wr_hit[p] == '0) |=> $stable(mbx[p]));

        assert_cause_in_status_R9: assert property (@(posedge clk) disable iff (rst)
            (cause[p] & ~status[p]) == '0);

        assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
            ((clr_req[p] & ~set_req[Q]) != '0) |=>
                ((status[p] & $past(clr_req[p] & ~set_req[Q])) == '0));

        assert_set_wins_R13: assert property (@(posedge clk) disable iff (rst)
            (set_req[Q] != '0) |=> ((status[p] & $past(set_req[Q])) == $past(set_req[Q])));

        assert_irq_pending_R10: assert property (@(posedge clk) disable iff (rst)
            !irq_n[p] |-> (status[p] != '0));

        assert_reset_R12: assert property (@(posedge clk)
            rst |=> (mask[p] == '1 && status[p] == '0 && cause[p] == '0));
    end
endmodule

bind mbox_irq_ctrl mbox_irq_chk #(.N(N_MBX), .DW(DW)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .ev      (ev_v),
    .wr_hit  (wr_hit_v),
    .set_req (set_v),
    .clr_req (clr_v),
    .status  (status_v),
    .cause   (cause_v),
    .mask    (mask_v),
    .irq_n   (irq_n_v),
    .mbx     (mbx_v)
);

// File: tb/test_mbox_irq_ctrl.sv
module test_mbox_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  sel_n = 2'b11;
    logic [1:0]  we = 2'b00;
    logic [5:0]  addr [2];
    logic [1:0]  be [2];
    logic [15:0] wd [2];
    logic [15:0] rd [2];
    logic [1:0]  irq_n;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] mb [2][4];
    logic [3:0]  st [2];
    logic [3:0]  ca [2];
    logic [3:0]  mk [2];

    always #4 clk = ~clk;

    mbox_irq_ctrl i_mbox_irq_ctrl (
        .clk(clk), .rst(rst),
        .a_sel_n(sel_n[0]), .a_addr(addr[0]), .a_we(we[0]), .a_be(be[0]),
        .a_wdata(wd[0]), .a_rdata(rd[0]), .a_irq_n(irq_n[0]),
        .b_sel_n(sel_n[1]), .b_addr(addr[1]), .b_we(we[1]), .b_be(be[1]),
        .b_wdata(wd[1]), .b_rdata(rd[1]), .b_irq_n(irq_n[1])
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctrl_word(input int p);
        return {4'h0, ~st[p], ~ca[p], mk[p]};
    endfunction

    task automatic chk_irq(input string req);
        for (int p = 0; p < 2; p++)
            chk({15'h0, irq_n[p]}, {15'h0, ~|(ca[p] & ~mk[p])}, req);
    endtask

    task automatic acc(input int p, input logic [5:0] a, input logic w,
                       input logic [1:0] b, input logic [15:0] d, input string req);
        int q;
        logic [15:0] exp;
        q = 1 - p;
        exp = 16'h0;
        if (a >= 6'h20 && a <= 6'h23) exp = mb[p][a - 6'h20];
        else if (a >= 6'h24 && a <= 6'h27) exp = mb[q][a - 6'h24];
        else if (a == 6'h28) exp = ctrl_word(p);
        @(negedge clk);
        sel_n[p] = 1'b0; addr[p] = a; we[p] = w; be[p] = b; wd[p] = d;
        #1;
        if (!w) chk(rd[p], exp, req);
        @(negedge clk);
        sel_n[p] = 1'b1;
        if (w && a >= 6'h20 && a <= 6'h23) begin
            if (b[0]) mb[p][a - 6'h20][7:0]  = d[7:0];
            if (b[1]) begin
                mb[p][a - 6'h20][15:8] = d[15:8];
                st[q][a - 6'h20] = 1'b1;
                if (!mk[q][a - 6'h20]) ca[q][a - 6'h20] = 1'b1;
            end
        end
        if (w && a == 6'h28 && b[0]) mk[p] = d[3:0];
        if (!w && b[1] && a >= 6'h24 && a <= 6'h27) begin
            st[p][a - 6'h24] = 1'b0;
            ca[p][a - 6'h24] = 1'b0;
        end
        @(negedge clk);
        chk_irq(req);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            addr[p] = '0; be[p] = '0; wd[p] = '0;
            st[p] = '0; ca[p] = '0; mk[p] = 4'hF;
            for (int k = 0; k < 4; k++) mb[p][k] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk_irq("R12");
        for (int p = 0; p < 2; p++) begin
            acc(p, 6'h28, 1'b0, 2'b11, 16'h0, "R12");
            for (int k = 0; k < 4; k++) acc(p, 6'(32 + k), 1'b0, 2'b11, 16'h0, "R12");
        end

        // R8 mask write without low byte enable is ignored; full write unmasks
        acc(1, 6'h28, 1'b1, 2'b10, 16'h0000, "R8");
        acc(1, 6'h28, 1'b0, 2'b11, 16'h0, "R8");
        for (int p = 0; p < 2; p++) begin
            acc(p, 6'h28, 1'b1, 2'b01, 16'h0000, "R8");
            acc(p, 6'h28, 1'b0, 2'b11, 16'h0, "R8");
            acc(1 - p, 6'h28, 1'b0, 2'b11, 16'h0, "R8");
        end

        // R2 R3 R4 R5 R6 R7 R10 sweep over ports, mailboxes and byte enables
        for (int p = 0; p < 2; p++)
            for (int k = 0; k < 4; k++)
                for (int b = 1; b < 4; b++) begin
                    logic [15:0] d;
                    d = 16'(p * 16'h4000 + k * 16'h0900 + b * 16'h0031 + 16'h0102);
                    acc(p, 6'(32 + k), 1'b1, 2'(b), d, "R2");
                    acc(1 - p, 6'h28, 1'b0, 2'b11, 16'h0, "R3");
                    acc(1 - p, 6'(36 + k), 1'b0, 2'b01, 16'h0, "R4");
                    acc(p, 6'(32 + k), 1'b0, 2'b11, 16'h0, "R6");
                    acc(1 - p, 6'h28, 1'b0, 2'b11, 16'h0, "R7");
                    acc(1 - p, 6'(36 + k), 1'b0, 2'b10, 16'h0, "R5");
                    acc(1 - p, 6'h28, 1'b0, 2'b11, 16'h0, "R5");
                    acc(1 - p, 6'(36 + k), 1'b0, 2'b11, 16'h0, "R4");
                end

        // R9 masked source: status set, cause not; unmasking does not raise irq
        for (int k = 0; k < 4; k++) begin
            acc(1, 6'h28, 1'b1, 2'b01, 16'(1 << k), "R8");
            acc(0, 6'(32 + k), 1'b1, 2'b10, 16'hC300, "R9");
            acc(1, 6'h28, 1'b0, 2'b11, 16'h0, "R9");
            acc(1, 6'h28, 1'b1, 2'b01, 16'h0000, "R9");
            acc(1, 6'h28, 1'b0, 2'b11, 16'h0, "R9");
            acc(1, 6'(36 + k), 1'b0, 2'b10, 16'h0, "R5");
        end

        // R10 masking a pending cause drops irq, unmasking restores it
        acc(0, 6'h22, 1'b1, 2'b11, 16'h7E81, "R10");
        acc(1, 6'h28, 1'b1, 2'b01, 16'h0004, "R10");
        acc(1, 6'h28, 1'b0, 2'b11, 16'h0, "R10");
        acc(1, 6'h28, 1'b1, 2'b01, 16'h0000, "R10");
        acc(1, 6'h26, 1'b0, 2'b11, 16'h0, "R10");

        // R11 reserved addresses
        acc(0, 6'h00, 1'b1, 2'b11, 16'hFFFF, "R11");
        acc(0, 6'h24, 1'b1, 2'b11, 16'hFFFF, "R11");
        acc(1, 6'h29, 1'b1, 2'b11, 16'hFFFF, "R11");
        acc(1, 6'h3F, 1'b1, 2'b11, 16'hFFFF, "R11");
        acc(0, 6'h00, 1'b0, 2'b11, 16'h0, "R11");
        acc(1, 6'h2C, 1'b0, 2'b11, 16'h0, "R11");
        acc(1, 6'h1F, 1'b0, 2'b11, 16'h0, "R11");
        for (int p = 0; p < 2; p++) begin
            acc(p, 6'h28, 1'b0, 2'b11, 16'h0, "R11");
            for (int k = 0; k < 4; k++) acc(p, 6'(36 + k), 1'b0, 2'b01, 16'h0, "R11");
        end

        // R1 strobe held low: only the first data is taken
        @(negedge clk);
        sel_n[0] = 1'b0; addr[0] = 6'h21; we[0] = 1'b1; be[0] = 2'b11; wd[0] = 16'h1357;
        @(negedge clk);
        wd[0] = 16'h9BDF;
        repeat (3) @(negedge clk);
        sel_n[0] = 1'b1;
        mb[0][1] = 16'h1357; st[1][1] = 1'b1; ca[1][1] = 1'b1;
        @(negedge clk);
        acc(1, 6'h25, 1'b0, 2'b01, 16'h0, "R1");
        acc(1, 6'h28, 1'b0, 2'b11, 16'h0, "R1");
        acc(1, 6'h25, 1'b0, 2'b10, 16'h0, "R1");

        // R13 set and clear of the same mailbox on one edge
        @(negedge clk);
        sel_n = 2'b00;
        addr[0] = 6'h20; we[0] = 1'b1; be[0] = 2'b10; wd[0] = 16'hA500;
        addr[1] = 6'h24; we[1] = 1'b0; be[1] = 2'b10;
        @(negedge clk);
        sel_n = 2'b11;
        mb[0][0][15:8] = 8'hA5; st[1][0] = 1'b1;
        if (!mk[1][0]) ca[1][0] = 1'b1;
        @(negedge clk);
        chk_irq("R13");
        acc(1, 6'h28, 1'b0, 2'b11, 16'h0, "R13");
        acc(1, 6'h24, 1'b0, 2'b11, 16'h0, "R13");
        acc(1, 6'h28, 1'b0, 2'b11, 16'h0, "R13");

        summary();
    end
endmodule